// File: doc/BRIEF.md
# UART Pin Discovery Scanner

This block searches a bank of unidentified board pins for a serial transmit/receive pair. It has three ways to run a scan. A listen-only sweep watches every pin for a fixed window. A broadcast sweep takes each pin in turn as the candidate line into the target, sends one wake-up character on it at every configured bit rate, and watches all the other pins. A pairwise sweep tries each ordered (drive, watch) pair of pins on its own. Every level change that the scanner sees is reported as a one-cycle event. Each event carries the pin index, the new level, the scan kind, the pin being driven and the bit-rate slot.

The wake-up character is 0x0A, sent as 8N1 with the least significant bit first. Each bit lasts as many system clocks as the divisor in the selected bit-rate slot. A polarity control flips the idle level and every bit of the frame, for targets whose lines rest low. The scanner drives at most one pin at any time, and only while that pin is the candidate being driven. Every input passes through a two-flop synchronizer before change detection.

Top module: `uart_pin_scanner`

## Requirements
- R1: With mode_sel = 0 (listen-only), a start pulse opens a window of WINDOW_CYCLES clocks. In that window every pin is watched, and each level change produces an event with the pin index, the new level and evt_mode = 0. Changes made while no scan runs produce no event.
- R2: Changes on several watched pins in the same cycle are reported one per cycle, in rising pin index order, on consecutive cycles.
- R3: A pin change applied between clock edges appears as evt_valid on the fourth rising edge after it is applied, through the two-flop synchronizer, the change detector, the pending mask and the event register.
- R4: With mode_sel = 1 (broadcast), the driven pin steps from 0 to NPINS-1 as the outer loop and the bit-rate slot steps from 0 to NBAUD-1 as the inner loop. Each step sends one frame and then listens for LISTEN_CYCLES clocks. Events carry evt_mode = 1, evt_tx = driven pin and evt_baud = slot.
- R5: The frame is a low start bit, the bits of 0x0A LSB first, then a high stop bit. Each bit lasts the slot's divisor (field slot*DIV_W of baud_divs) in clocks. A receiving pin therefore shows six changes with levels 0,1,0,1,0,1. The gaps between them are 2d, d, d, d and 4d clocks.
- R6: With mode_sel = 2 (pairwise), steps run over the driven pin (outer loop), then the watched pin (middle loop, skipping the driven pin), then the slot (inner loop). Only the watched pin can raise events, tagged evt_mode = 2.
- R7: With invert = 1, the driven line idles low and every frame bit is the complement of R5, so a receiving pin shows the levels 1,0,1,0,1,0.
- R8: At most one bit of pin_oe is set at any time. It is set only for the current driven pin during broadcast or pairwise steps, and never while idle or in a listen-only window.
- R9: In broadcast mode, the driven pin itself never produces an event.
- R10: busy rises on an accepted start and falls when the scan ends. A start while busy, or a start with mode_sel = 3, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a scan |
| mode_sel | input | 2 | 0 listen-only, 1 broadcast, 2 pairwise |
| invert | input | 1 | Lines idle low and frame bits are inverted |
| baud_divs | input | NBAUD*DIV_W | Clocks per bit for each bit-rate slot, slot 0 lowest |
| pin_in | input | NPINS | Sampled levels of the target pins |
| pin_out | output | NPINS | Drive values for the target pins |
| pin_oe | output | NPINS | Drive enables; a cleared bit leaves the pin high impedance |
| busy | output | 1 | A scan is running |
| evt_valid | output | 1 | An event is present this cycle |
| evt_pin | output | $clog2(NPINS) | Index of the pin that changed |
| evt_level | output | 1 | New level of that pin |
| evt_mode | output | 2 | Scan kind that was running |
| evt_tx | output | $clog2(NPINS) | Pin being driven (0 in listen-only) |
| evt_baud | output | $clog2(NBAUD) | Bit-rate slot (0 in listen-only) |

## Verification
If the step counters hold a wrong value, events show up with the wrong evt_tx or evt_baud tags, or the event count of a sweep changes. This is seen as soon as the first group of six echo events from a looped-back pin pair arrives. A fault in the frame bit counter or the divisor counter changes the spacing between those six events within one frame time. A fault in the pending mask or the synchronizer shifts the four-edge latency, or breaks the one-per-cycle ordering of simultaneous changes, on the very next change. A wrong drive enable shows up on pin_oe in the same cycle.

// File: rtl/uart_scan_pkg.sv
package uart_scan_pkg;

  typedef enum logic [1:0] {
    SCAN_LISTEN = 2'd0,
    SCAN_BROAD  = 2'd1,
    SCAN_PAIR   = 2'd2
  } scan_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WINDOW = 3'd1,
    ST_LAUNCH = 3'd2,
    ST_SEND   = 3'd3,
    ST_LISTEN = 3'd4
  } scan_state_e;

  localparam int FRAME_BITS = 10;

endpackage

// File: rtl/scan_pin_sync.sv
module scan_pin_sync #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] level,
  output logic [NPINS-1:0] toggled
);

  logic [NPINS-1:0] meta_q, sync_q, prev_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= pin_in[g];
        sync_q[g] <= meta_q[g];
        prev_q[g] <= sync_q[g];
      end
    end
    assign toggled[g] = sync_q[g] ^ prev_q[g];
  end

  assign level = sync_q;

endmodule

// File: rtl/scan_frame_tx.sv
module scan_frame_tx
  import uart_scan_pkg::*;
#(
  parameter int         DIV_W     = 16,
  parameter logic [7:0] WAKE_BYTE = 8'h0A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DIV_W-1:0] div,
  output logic             line,
  output logic             active
);

  localparam int BIT_CW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shift_q, shift_n;
  logic [BIT_CW-1:0]     left_q, left_n;
  logic [DIV_W-1:0]      cnt_q, cnt_n;
  logic                  act_q, act_n;

  always_comb begin
    shift_n = shift_q;
    left_n  = left_q;
    cnt_n   = cnt_q;
    act_n   = act_q;
    if (!act_q) begin
      if (go) begin
        shift_n = {1'b1, WAKE_BYTE, 1'b0};
        left_n  = BIT_CW'(FRAME_BITS - 1);
        cnt_n   = div - 1'b1;
        act_n   = 1'b1;
      end
    end else if (cnt_q == '0) begin
      if (left_q == '0) begin
        act_n = 1'b0;
      end else begin
        shift_n = {1'b1, shift_q[FRAME_BITS-1:1]};
        left_n  = left_q - 1'b1;
        cnt_n   = div - 1'b1;
      end
    end else begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '1;
      left_q  <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
    end else begin
      shift_q <= shift_n;
      left_q  <= left_n;
      cnt_q   <= cnt_n;
      act_q   <= act_n;
    end
  end

  assign active = act_q;
  assign line   = act_q ? shift_q[0] : 1'b1;

  // R5: a bit holds its level until its divisor count runs out
  a_r5_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q != '0) |=> $stable(line));

  // R5: a go request while idle always opens a frame
  a_r5_frame_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !act_q) |=> (act_q && line == 1'b0));

endmodule

// File: rtl/scan_event_queue.sv
module scan_event_queue #(
  parameter int NPINS = 8,
  parameter int PIN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] watch,
  input  logic [NPINS-1:0] toggled,
  input  logic [NPINS-1:0] level,
  output logic             evt_valid,
  output logic [PIN_W-1:0] evt_pin,
  output logic             evt_level,
  output logic             empty
);

  logic [NPINS-1:0] pend_q, pend_n, lvl_q, lvl_n, pick_oh;
  logic [PIN_W-1:0] pick_idx;
  logic             vld_q;
  logic [PIN_W-1:0] pin_q;
  logic             plvl_q;

  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        pick_oh  = '0;
        pick_oh[i] = 1'b1;
        pick_idx = PIN_W'(i);
      end
    end
  end

  always_comb begin
    pend_n = (pend_q & ~pick_oh) | (toggled & watch);
    for (int i = 0; i < NPINS; i++) begin
      lvl_n[i] = (toggled[i] && watch[i]) ? level[i] : lvl_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      lvl_q  <= '0;
      vld_q  <= 1'b0;
      pin_q  <= '0;
      plvl_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      lvl_q  <= lvl_n;
      vld_q  <= |pend_q;
      pin_q  <= pick_idx;
      plvl_q <= lvl_q[pick_idx];
    end
  end

  assign evt_valid = vld_q;
  assign evt_pin   = pin_q;
  assign evt_level = plvl_q;
  assign empty     = (pend_q == '0);

  // R2: any pending change is emitted on the next cycle
  a_r2_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0) |=> evt_valid);

  // R2: a pending bit leaves only by being emitted
  a_r2_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0) |=> ($countones(pend_q) >= $countones($past(pend_q)) - 1));

endmodule

// File: rtl/uart_pin_scanner.sv
module uart_pin_scanner
  import uart_scan_pkg::*;
#(
  parameter int NPINS         = 8,
  parameter int NBAUD         = 4,
  parameter int DIV_W         = 16,
  parameter int WINDOW_CYCLES = 400_000_000,
  parameter int LISTEN_CYCLES = 1_000_000,
  localparam int PIN_W        = $clog2(NPINS),
  localparam int BAUD_W       = (NBAUD > 1) ? $clog2(NBAUD) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [1:0]             mode_sel,
  input  logic                   invert,
  input  logic [NBAUD*DIV_W-1:0] baud_divs,
  input  logic [NPINS-1:0]       pin_in,
  output logic [NPINS-1:0]       pin_out,
  output logic [NPINS-1:0]       pin_oe,
  output logic                   busy,
  output logic                   evt_valid,
  output logic [PIN_W-1:0]       evt_pin,
  output logic                   evt_level,
  output logic [1:0]             evt_mode,
  output logic [PIN_W-1:0]       evt_tx,
  output logic [BAUD_W-1:0]      evt_baud
);

  localparam int MAXC  = (WINDOW_CYCLES > LISTEN_CYCLES) ? WINDOW_CYCLES : LISTEN_CYCLES;
  localparam int TMR_W = $clog2(MAXC + 1);

  scan_state_e       st_q, st_n;
  scan_kind_e        kind_q, kind_n;
  logic              inv_q, inv_n;
  logic [PIN_W-1:0]  tx_q, tx_n, rx_q, rx_n;
  logic [BAUD_W-1:0] bd_q, bd_n;
  logic [TMR_W-1:0]  tmr_q, tmr_n;

  logic [NPINS-1:0]  level, toggled, watch;
  logic              q_empty, frame_line, frame_active, frame_go;
  logic [DIV_W-1:0]  cur_div;
  logic              driving;

  scan_pin_sync #(.NPINS(NPINS)) i_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .level(level), .toggled(toggled)
  );

  scan_event_queue #(.NPINS(NPINS), .PIN_W(PIN_W)) i_queue (
    .clk(clk), .rst_n(rst_n), .watch(watch), .toggled(toggled), .level(level),
    .evt_valid(evt_valid), .evt_pin(evt_pin), .evt_level(evt_level), .empty(q_empty)
  );

  assign cur_div  = baud_divs[bd_q*DIV_W +: DIV_W];
  assign frame_go = (st_q == ST_LAUNCH);

  scan_frame_tx #(.DIV_W(DIV_W)) i_frame (
    .clk(clk), .rst_n(rst_n), .go(frame_go), .div(cur_div),
    .line(frame_line), .active(frame_active)
  );

  assign driving = (st_q == ST_LAUNCH) || (st_q == ST_SEND) || (st_q == ST_LISTEN);

  // watch mask and pin drive
  always_comb begin
    watch   = '0;
    pin_oe  = '0;
    pin_out = '0;
    if (st_q == ST_WINDOW) begin
      watch = '1;
    end else if (driving) begin
      pin_oe[tx_q]  = 1'b1;
      pin_out[tx_q] = frame_line ^ inv_q;
      if (kind_q == SCAN_PAIR) begin
        watch[rx_q] = 1'b1;
      end else begin
        watch       = '1;
        watch[tx_q] = 1'b0;
      end
    end
  end

  // step advance
  logic [PIN_W:0] rx_step, rx_skip;
  logic           rx_wrap, tx_last, bd_last, quiet, step_end, scan_done;

  always_comb begin
    rx_step = {1'b0, rx_q} + 1'b1;
    rx_skip = (rx_step == {1'b0, tx_q}) ? rx_step + 1'b1 : rx_step;
    rx_wrap = (rx_skip >= (PIN_W+1)'(NPINS));
    tx_last = (tx_q == PIN_W'(NPINS - 1));
    bd_last = (bd_q == BAUD_W'(NBAUD - 1));
    quiet   = q_empty && ((toggled & watch) == '0) && (tmr_q == '0);
  end

  always_comb begin
    st_n      = st_q;
    kind_n    = kind_q;
    inv_n     = inv_q;
    tx_n      = tx_q;
    rx_n      = rx_q;
    bd_n      = bd_q;
    tmr_n     = (tmr_q != '0) ? tmr_q - 1'b1 : tmr_q;
    step_end  = 1'b0;
    scan_done = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start && mode_sel != 2'd3) begin
          kind_n = scan_kind_e'(mode_sel);
          inv_n  = invert;
          tx_n   = '0;
          rx_n   = PIN_W'(1);
          bd_n   = '0;
          if (mode_sel == 2'd0) begin
            st_n  = ST_WINDOW;
            tmr_n = TMR_W'(WINDOW_CYCLES - 1);
          end else begin
            st_n = ST_LAUNCH;
          end
        end
      end
      ST_WINDOW: if (quiet) st_n = ST_IDLE;
      ST_LAUNCH: st_n = ST_SEND;
      ST_SEND: begin
        if (!frame_active) begin
          st_n  = ST_LISTEN;
          tmr_n = TMR_W'(LISTEN_CYCLES - 1);
        end
      end
      ST_LISTEN: if (quiet) step_end = 1'b1;
      default: st_n = ST_IDLE;
    endcase

    if (step_end) begin
      st_n = ST_LAUNCH;
      if (!bd_last) begin
        bd_n = bd_q + 1'b1;
      end else begin
        bd_n = '0;
        if (kind_q == SCAN_PAIR && !rx_wrap) begin
          rx_n = rx_skip[PIN_W-1:0];
        end else if (tx_last) begin
          scan_done = 1'b1;
        end else begin
          tx_n = tx_q + 1'b1;
          rx_n = '0;
        end
      end
      if (scan_done) st_n = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= SCAN_LISTEN;
      inv_q  <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      bd_q   <= '0;
      tmr_q  <= '0;
    end else begin
      st_q   <= st_n;
      kind_q <= kind_n;
      inv_q  <= inv_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      bd_q   <= bd_n;
      tmr_q  <= tmr_n;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign evt_mode = kind_q;
  assign evt_tx   = (kind_q == SCAN_LISTEN) ? '0 : tx_q;
  assign evt_baud = (kind_q == SCAN_LISTEN) ? '0 : bd_q;

  // R8: never more than one pin driven
  a_r8_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pin_oe));

  // R8: no drive while idle
  a_r8_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pin_oe == '0));

  // R9: the driven pin never reports itself in broadcast mode
  a_r9_tx_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_mode == SCAN_BROAD) |-> (evt_pin != evt_tx));

  // R6: pairwise events come only from the watched pin
  a_r6_rx_only: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_mode == SCAN_PAIR) |-> (evt_pin == rx_q));

  // R7: a driven line outside a frame rests at the idle level
  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe != '0) && !frame_active) |-> ((pin_out & pin_oe) == (inv_q ? '0 : pin_oe)));

  // R10: a start is ignored while a scan runs
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && st_q == ST_WINDOW) |=> (kind_q == SCAN_LISTEN));

endmodule

// File: tb/test_uart_pin_scanner.sv
`timescale 1ns/1ps
module test_uart_pin_scanner;

  localparam int N   = 6;
  localparam int NB  = 3;
  localparam int DW  = 8;
  localparam int WIN = 200;
  localparam int LIS = 40;
  localparam int TGT_RX = 1;
  localparam int TGT_TX = 4;

  // [11:10] mode, [9] invert, [8:1] expected event count, [0] first level
  localparam logic [11:0] VECS [4] = '{
    {2'd1, 1'b0, 8'd18, 1'b0},
    {2'd2, 1'b0, 8'd18, 1'b0},
    {2'd1, 1'b1, 8'd18, 1'b1},
    {2'd2, 1'b1, 8'd18, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [1:0] mode_sel;
  logic invert;
  logic [NB*DW-1:0] baud_divs;
  logic [N-1:0] pin_in, pin_out, pin_oe, bench_lvl;
  logic busy, evt_valid, evt_level;
  logic [2:0] evt_pin, evt_tx;
  logic [1:0] evt_mode, evt_baud;

  always #2.5 clk = ~clk;

  uart_pin_scanner #(.NPINS(N), .NBAUD(NB), .DIV_W(DW),
                     .WINDOW_CYCLES(WIN), .LISTEN_CYCLES(LIS)) i_uart_pin_scanner (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel), .invert(invert),
    .baud_divs(baud_divs), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .busy(busy), .evt_valid(evt_valid), .evt_pin(evt_pin), .evt_level(evt_level),
    .evt_mode(evt_mode), .evt_tx(evt_tx), .evt_baud(evt_baud)
  );

  // target model: its receive pin echoes straight onto its transmit pin
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (pin_oe[i]) pin_in[i] = pin_out[i];
      else if (i == TGT_TX && pin_oe[TGT_RX]) pin_in[i] = pin_out[TGT_RX];
      else pin_in[i] = bench_lvl[i];
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ev_n;
  int ev_pin [64];
  int ev_lvl [64];
  int ev_mode [64];
  int ev_tx [64];
  int ev_bd [64];
  int ev_t [64];
  bit oe_multi = 1'b0;
  bit oe_in_listen = 1'b0;
  bit listen_phase = 1'b0;

  always @(negedge clk) begin
    if (evt_valid && ev_n < 64) begin
      ev_pin[ev_n]  = evt_pin;
      ev_lvl[ev_n]  = evt_level;
      ev_mode[ev_n] = evt_mode;
      ev_tx[ev_n]   = evt_tx;
      ev_bd[ev_n]   = evt_baud;
      ev_t[ev_n]    = cyc;
      ev_n = ev_n + 1;
    end
    if ($countones(pin_oe) > 1) oe_multi = 1'b1;
    if (listen_phase && pin_oe != '0) oe_in_listen = 1'b1;
  end

  int checks = 0;
  int failures = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start(input logic [1:0] m, input logic inv);
    @(negedge clk);
    mode_sel = m;
    invert   = inv;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60000 && busy; i++) @(negedge clk);
    cycles(8);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int t_drive;
    int t_start;
    rst_n = 1'b0;
    start = 1'b0;
    mode_sel = 2'd0;
    invert = 1'b0;
    baud_divs = {8'd8, 8'd5, 8'd3};
    bench_lvl = '1;
    ev_n = 0;
    cycles(4);
    rst_n = 1'b1;
    cycles(6);

    // reset state
    check("R10", "busy after reset", busy, 0);
    check("R8", "pin_oe after reset", pin_oe, 0);
    check("R1", "evt_valid after reset", evt_valid, 0);

    // table of active sweeps
    for (int v = 0; v < 4; v++) begin
      logic [1:0] m;
      logic inv;
      int exp_n;
      logic first;
      m = VECS[v][11:10];
      inv = VECS[v][9];
      exp_n = VECS[v][8:1];
      first = VECS[v][0];
      bench_lvl = inv ? '0 : '1;
      cycles(6);
      ev_n = 0;
      pulse_start(m, inv);
      check("R10", "busy during sweep", busy, 1);
      wait_idle();
      check(m == 2'd1 ? "R4" : "R6", "event count", ev_n, exp_n);
      if (ev_n == exp_n) begin
        for (int k = 0; k < exp_n; k++) begin
          check("R9", "event pin", ev_pin[k], TGT_TX);
          check("R4", "event driven pin tag", ev_tx[k], TGT_RX);
          check("R4", "event slot tag", ev_bd[k], k / 6);
          check("R6", "event mode tag", ev_mode[k], m);
          check(inv ? "R7" : "R5", "event level", ev_lvl[k], first ^ (k % 2));
        end
        check("R5", "gap start to bit1 (d=8)", ev_t[13] - ev_t[12], 16);
        check("R5", "gap bit1 to bit2 (d=8)", ev_t[14] - ev_t[13], 8);
        check("R5", "gap bit3 to bit4 (d=8)", ev_t[16] - ev_t[15], 8);
        check("R5", "gap bit4 to stop (d=8)", ev_t[17] - ev_t[16], 32);
        check("R5", "gap start to bit1 (d=3)", ev_t[1] - ev_t[0], 6);
      end
    end
    check("R8", "more than one driven pin seen", oe_multi, 0);

    // listen-only window with simultaneous changes
    bench_lvl = '1;
    cycles(6);
    ev_n = 0;
    listen_phase = 1'b1;
    pulse_start(2'd0, 1'b0);
    t_start = cyc;
    cycles(20);
    bench_lvl[0] = 1'b0;
    bench_lvl[3] = 1'b0;
    t_drive = cyc;
    cycles(3);
    check("R3", "no event after three edges", evt_valid, 0);
    cycles(1);
    check("R3", "event on fourth edge", evt_valid, 1);
    cycles(20);
    bench_lvl[2] = 1'b0;
    // second start while busy must be ignored
    pulse_start(2'd1, 1'b0);
    for (int i = 0; i < 400 && (cyc - t_start) < WIN - 5; i++) @(negedge clk);
    check("R10", "busy near window end", busy, 1);
    cycles(12);
    check("R10", "idle after window", busy, 0);
    listen_phase = 1'b0;
    check("R1", "window event count", ev_n, 3);
    check("R2", "first simultaneous pin", ev_pin[0], 0);
    check("R2", "second simultaneous pin", ev_pin[1], 3);
    check("R2", "simultaneous spacing", ev_t[1] - ev_t[0], 1);
    check("R3", "latency in edges", ev_t[0] - t_drive, 4);
    check("R1", "later pin index", ev_pin[2], 2);
    check("R1", "new level", ev_lvl[2], 0);
    check("R1", "mode tag", ev_mode[0], 0);
    check("R8", "drive during window or ignored start", oe_in_listen, 0);

    // no events outside a scan
    ev_n = 0;
    bench_lvl[5] = 1'b0;
    cycles(12);
    check("R1", "events while idle", ev_n, 0);

    // reserved mode ignored
    pulse_start(2'd3, 1'b0);
    cycles(2);
    check("R10", "busy after mode 3 start", busy, 0);
    check("R8", "pin_oe after mode 3 start", pin_oe, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule